// File: doc/BRIEF.md
# Stream Command Dispatcher with Port Scoreboard

This block takes stream commands from a small host core one at a time, through a valid/ready queue head, and hands each one to the stream engine that runs it. There are five engines: memory read, memory write, scratchpad read, scratchpad write and recurrence. Before a stream command leaves, the block checks two things. The vector ports the command names must not be held by an earlier stream, and the target engine must report that it is free. If either check fails, the head of the queue stalls, so commands leave in program order, at most one per cycle.

Ports are tracked with one busy bit each, kept separately for input vector ports and output vector ports. A busy bit is set when a command on that port issues. It is cleared when the engine pulses the release line for that port. Each bit also records whether a scratchpad engine holds the port. From that record the block can hold barrier commands until the streams they wait on have drained:
- a scratchpad-read barrier waits for scratchpad reads;
- a scratchpad-write barrier waits for scratchpad writes;
- a full barrier waits for every stream.

A configure command also waits until no port is held, and then leaves on its own strobe.

Top module: `sd_dispatcher`

## Requirements
- R1: While `rst_n` is low, `cmd_ready`, `eng_issue` and `cfg_issue` are all 0. On the first cycle after reset every port is free, so a full barrier is ready at once.
- R2: Opcode values select the engine. `eng_issue` bit 0 is memory read, bit 1 memory write, bit 2 scratchpad read, bit 3 scratchpad write and bit 4 recurrence. The opcodes route as follows:
  - 1 (memory to port) goes to bit 0;
  - 2 (port to memory) goes to bit 1;
  - 3 (scratchpad to port) goes to bit 2;
  - 4 (port to scratchpad) goes to bit 3;
  - 5 (constant to port) and 6 (port to port) go to bit 4.
- R3: Opcodes 1, 3, 5 and 6 hold input port `cmd_dst`. Opcodes 2, 4 and 6 hold output port `cmd_src`. Input and output ports are separate namespaces.
- R4: A command that uses an input port whose busy bit is set is not accepted. The bit clears on the clock edge that samples that port's `in_rel` bit, and the stalled command becomes ready in the next cycle.
- R5: The same stall-and-release rule as R4 applies to output ports, using `out_rel`.
- R6: A stream command is not accepted while its engine's `eng_free` bit is low. It becomes ready in the same cycle that bit goes high.
- R7: At most one bit of `{eng_issue, cfg_issue}` is high in any cycle, and only when `cmd_valid && cmd_ready`. In that cycle `iss_src`, `iss_dst`, `iss_addr` and `iss_len` equal the command's fields.
- R8: A scratchpad-read barrier (opcode 7) is held while any input port is held by a scratchpad-read stream. Streams from other engines do not hold it. It issues nothing.
- R9: A scratchpad-write barrier (opcode 8) is held while any output port is held by a scratchpad-write stream. Streams from other engines do not hold it. It issues nothing.
- R10: A full barrier (opcode 9) is held while any input or output port is busy. It issues nothing.
- R11: A configure command (opcode 0) waits until no port is busy, then pulses `cfg_issue`.
- R12: Opcodes 10 to 15 are accepted at once and issue nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Queue head holds a command |
| cmd_ready | output | 1 | Queue head is consumed this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_src | input | PORT_W | Source (output) vector port |
| cmd_dst | input | PORT_W | Destination (input) vector port |
| cmd_addr | input | ADDR_W | Address or constant operand |
| cmd_len | input | LEN_W | Element count |
| eng_free | input | 5 | Per-engine free flags |
| in_rel | input | NUM_PORTS | Input-port stream completion pulses |
| out_rel | input | NUM_PORTS | Output-port stream completion pulses |
| eng_issue | output | 5 | One-hot issue strobe per engine |
| cfg_issue | output | 1 | Configure command strobe |
| iss_src | output | PORT_W | Issued source port |
| iss_dst | output | PORT_W | Issued destination port |
| iss_addr | output | ADDR_W | Issued address operand |
| iss_len | output | LEN_W | Issued length |

## Verification
The bench targets the release edge. A stalled command must become ready in the cycle right after the release pulse, neither earlier nor held a cycle too long. It also checks that the scratchpad barriers ignore streams from the other engines: a design that counted every stream would keep those barriers stalled after the scratchpad port was freed. A port-to-port stream must hold its output port as well as its input port, or a configure command would slip past it. Finally, an unknown opcode must drain without reaching any engine; a design that fell through to a default engine would pop an unexpected item at the monitor.

// File: rtl/sd_pkg.sv
// Shared encodings for the stream command dispatcher.
// Assumes a 4-bit opcode field and five engines in a fixed bit order.
package sd_pkg;

    localparam int ENG_N = 5;

    typedef enum logic [3:0] {
        OP_CFG     = 4'd0,
        OP_MEM2P   = 4'd1,
        OP_P2MEM   = 4'd2,
        OP_SP2P    = 4'd3,
        OP_P2SP    = 4'd4,
        OP_CONST   = 4'd5,
        OP_RECUR   = 4'd6,
        OP_BAR_RD  = 4'd7,
        OP_BAR_WR  = 4'd8,
        OP_BAR_ALL = 4'd9
    } op_e;

    // Bit positions of the engines in the issue vector
    localparam int ENG_MRD = 0;
    localparam int ENG_MWR = 1;
    localparam int ENG_SRD = 2;
    localparam int ENG_SWR = 3;
    localparam int ENG_REC = 4;

    // What must be true before the head command may leave
    typedef enum logic [1:0] {
        GATE_STREAM = 2'd0,
        GATE_EMPTY  = 2'd1,
        GATE_SPRD   = 2'd2,
        GATE_SPWR   = 2'd3
    } gate_e;

    typedef struct packed {
        logic [ENG_N-1:0] eng;
        logic             use_in;
        logic             use_out;
        logic             in_tag;
        logic             out_tag;
        logic             is_cfg;
        gate_e            gate;
    } dec_t;

endpackage

// File: rtl/sd_cmd_decode.sv
// Opcode decoder: maps an opcode to its target engine, the ports it
// holds, and the readiness rule it follows. Pure combinational logic.
// Assumes unknown opcodes need no engine and no port.
module sd_cmd_decode
    import sd_pkg::*;
(
    input  logic [3:0] op,
    output dec_t       dec
);

    // Decode opcode into routing and gating fields
    always_comb begin
        dec = '0;
        dec.gate = GATE_STREAM;
        case (op_e'(op))
            OP_CFG: begin
                dec.is_cfg = 1'b1;
                dec.gate   = GATE_EMPTY;
            end
            OP_MEM2P: begin
                dec.eng[ENG_MRD] = 1'b1;
                dec.use_in       = 1'b1;
            end
            OP_P2MEM: begin
                dec.eng[ENG_MWR] = 1'b1;
                dec.use_out      = 1'b1;
            end
            OP_SP2P: begin
                dec.eng[ENG_SRD] = 1'b1;
                dec.use_in       = 1'b1;
                dec.in_tag       = 1'b1;
            end
            OP_P2SP: begin
                dec.eng[ENG_SWR] = 1'b1;
                dec.use_out      = 1'b1;
                dec.out_tag      = 1'b1;
            end
            OP_CONST: begin
                dec.eng[ENG_REC] = 1'b1;
                dec.use_in       = 1'b1;
            end
            OP_RECUR: begin
                dec.eng[ENG_REC] = 1'b1;
                dec.use_in       = 1'b1;
                dec.use_out      = 1'b1;
            end
            OP_BAR_RD:  dec.gate = GATE_SPRD;
            OP_BAR_WR:  dec.gate = GATE_SPWR;
            OP_BAR_ALL: dec.gate = GATE_EMPTY;
            default:    dec.gate = GATE_STREAM;
        endcase
    end

endmodule

// File: rtl/sd_port_sb.sv
// One bank of the port scoreboard: a busy bit and a scratchpad tag per
// port. Set on issue, cleared by a completion pulse; set wins a tie.
// Assumes at most one set per cycle.
module sd_port_sb #(
    parameter  int NUM   = 8,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             set_tag,
    input  logic [NUM-1:0]   clr,
    output logic [NUM-1:0]   busy,
    output logic [NUM-1:0]   tag
);

    for (genvar p = 0; p < NUM; p++) begin : g_bit
        // Track ownership of port p
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[p] <= 1'b0;
                tag[p]  <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(p)) begin
                busy[p] <= 1'b1;
                tag[p]  <= set_tag;
            end else if (clr[p]) begin
                busy[p] <= 1'b0;
                tag[p]  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sd_issue_gate.sv
// Readiness logic for the queue head: port hazards and engine
// availability for streams, drain conditions for barriers and configure.
// Assumes scoreboard outputs are registered.
module sd_issue_gate
    import sd_pkg::*;
#(
    parameter  int NUM_PORTS = 8,
    localparam int PORT_W    = $clog2(NUM_PORTS)
) (
    input  dec_t                 dec,
    input  logic [PORT_W-1:0]    src,
    input  logic [PORT_W-1:0]    dst,
    input  logic [NUM_PORTS-1:0] in_busy,
    input  logic [NUM_PORTS-1:0] in_tag,
    input  logic [NUM_PORTS-1:0] out_busy,
    input  logic [NUM_PORTS-1:0] out_tag,
    input  logic [ENG_N-1:0]     eng_free,
    output logic                 ready
);

    logic eng_ok, in_hz, out_hz, all_idle, sprd_pend, spwr_pend;

    // Hazard and drain terms
    always_comb begin
        eng_ok    = (dec.eng == '0) || ((dec.eng & eng_free) != '0);
        in_hz     = dec.use_in  && in_busy[dst];
        out_hz    = dec.use_out && out_busy[src];
        all_idle  = (in_busy == '0) && (out_busy == '0);
        sprd_pend = |(in_busy & in_tag);
        spwr_pend = |(out_busy & out_tag);
    end

    // Select the rule for this command class
    always_comb begin
        case (dec.gate)
            GATE_STREAM: ready = eng_ok && !in_hz && !out_hz;
            GATE_EMPTY:  ready = all_idle;
            GATE_SPRD:   ready = !sprd_pend;
            GATE_SPWR:   ready = !spwr_pend;
            default:     ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/sd_dispatcher.sv
// Stream command dispatcher. Consumes the queue head in order, one
// command per cycle at most, routes streams to engines, drives configure
// strobes and resolves barriers against a bit-per-port scoreboard.
// Assumes engines pulse in_rel/out_rel once per completed port stream.
module sd_dispatcher
    import sd_pkg::*;
#(
    parameter  int NUM_PORTS = 8,
    parameter  int ADDR_W    = 32,
    parameter  int LEN_W     = 16,
    localparam int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [3:0]           cmd_op,
    input  logic [PORT_W-1:0]    cmd_src,
    input  logic [PORT_W-1:0]    cmd_dst,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [LEN_W-1:0]     cmd_len,
    input  logic [ENG_N-1:0]     eng_free,
    input  logic [NUM_PORTS-1:0] in_rel,
    input  logic [NUM_PORTS-1:0] out_rel,
    output logic [ENG_N-1:0]     eng_issue,
    output logic                 cfg_issue,
    output logic [PORT_W-1:0]    iss_src,
    output logic [PORT_W-1:0]    iss_dst,
    output logic [ADDR_W-1:0]    iss_addr,
    output logic [LEN_W-1:0]     iss_len
);

    dec_t                 dec;
    logic                 gate_ready;
    logic                 fire;
    logic [NUM_PORTS-1:0] in_busy, in_tag, out_busy, out_tag;

    sd_cmd_decode u_dec (
        .op  (cmd_op),
        .dec (dec)
    );

    sd_issue_gate #(.NUM_PORTS(NUM_PORTS)) u_gate (
        .dec      (dec),
        .src      (cmd_src),
        .dst      (cmd_dst),
        .in_busy  (in_busy),
        .in_tag   (in_tag),
        .out_busy (out_busy),
        .out_tag  (out_tag),
        .eng_free (eng_free),
        .ready    (gate_ready)
    );

    // Handshake and issue strobes
    always_comb begin
        cmd_ready = rst_n && gate_ready;
        fire      = cmd_valid && cmd_ready;
        eng_issue = fire ? dec.eng : '0;
        cfg_issue = fire && dec.is_cfg;
        iss_src   = cmd_src;
        iss_dst   = cmd_dst;
        iss_addr  = cmd_addr;
        iss_len   = cmd_len;
    end

    sd_port_sb #(.NUM(NUM_PORTS)) u_sb_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (fire && dec.use_in),
        .set_idx (cmd_dst),
        .set_tag (dec.in_tag),
        .clr     (in_rel),
        .busy    (in_busy),
        .tag     (in_tag)
    );

    sd_port_sb #(.NUM(NUM_PORTS)) u_sb_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (fire && dec.use_out),
        .set_idx (cmd_src),
        .set_tag (dec.out_tag),
        .clr     (out_rel),
        .busy    (out_busy),
        .tag     (out_tag)
    );

endmodule

// File: rtl/sd_dispatcher_chk.sv
// Property checker for the dispatcher, bound to every instance.
// Observes ports and the two scoreboard busy vectors.
module sd_dispatcher_chk #(
    parameter  int NUM_PORTS = 8,
    localparam int PORT_W    = $clog2(NUM_PORTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [3:0]           cmd_op,
    input logic [PORT_W-1:0]    cmd_src,
    input logic [PORT_W-1:0]    cmd_dst,
    input logic [4:0]           eng_free,
    input logic [4:0]           eng_issue,
    input logic                 cfg_issue,
    input logic [NUM_PORTS-1:0] in_busy,
    input logic [NUM_PORTS-1:0] out_busy
);

    logic in_op, out_op;

    // Opcode classes as given by the requirements
    always_comb begin
        in_op  = (cmd_op == 4'd1) || (cmd_op == 4'd3) || (cmd_op == 4'd5) || (cmd_op == 4'd6);
        out_op = (cmd_op == 4'd2) || (cmd_op == 4'd4) || (cmd_op == 4'd6);
    end

    p_one_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_issue, cfg_issue}));

    p_issue_handshake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|eng_issue) || cfg_issue) |-> (cmd_valid && cmd_ready));

    p_engine_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_issue) |-> ((eng_issue & ~eng_free) == 5'd0));

    p_in_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && in_op && in_busy[cmd_dst]) |-> !cmd_ready);

    p_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && in_op) |=> in_busy[$past(cmd_dst)]);

    p_out_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && out_op && out_busy[cmd_src]) |-> !cmd_ready);

    p_cfg_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_issue |-> ((in_busy == '0) && (out_busy == '0)));

    p_bar_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd9 && ((|in_busy) || (|out_busy))) |-> !cmd_ready);

endmodule

bind sd_dispatcher sd_dispatcher_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_src   (cmd_src),
    .cmd_dst   (cmd_dst),
    .eng_free  (eng_free),
    .eng_issue (eng_issue),
    .cfg_issue (cfg_issue),
    .in_busy   (in_busy),
    .out_busy  (out_busy)
);

// File: tb/sim_sd_dispatcher.sv
// Scoreboard bench: the driver queues expected issues, the monitor pops
// and compares them as the dispatcher produces strobes.
module sim_sd_dispatcher;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int ITEM_W = 60;

    localparam logic [4:0] E_MRD = 5'b00001;
    localparam logic [4:0] E_MWR = 5'b00010;
    localparam logic [4:0] E_SRD = 5'b00100;
    localparam logic [4:0] E_SWR = 5'b01000;
    localparam logic [4:0] E_REC = 5'b10000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_ready;
    logic [3:0]  cmd_op;
    logic [2:0]  cmd_src, cmd_dst;
    logic [31:0] cmd_addr;
    logic [15:0] cmd_len;
    logic [4:0]  eng_free;
    logic [NP-1:0] in_rel, out_rel;
    logic [4:0]  eng_issue;
    logic        cfg_issue;
    logic [2:0]  iss_src, iss_dst;
    logic [31:0] iss_addr;
    logic [15:0] iss_len;

    int n_checks = 0;
    int n_fail = 0;
    logic acc_flag = 1'b0;
    logic [ITEM_W-1:0] exp_q[$];
    logic [ITEM_W-1:0] mon_got, mon_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_dispatcher u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .eng_free(eng_free), .in_rel(in_rel), .out_rel(out_rel),
        .eng_issue(eng_issue), .cfg_issue(cfg_issue), .iss_src(iss_src),
        .iss_dst(iss_dst), .iss_addr(iss_addr), .iss_len(iss_len)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: samples one unit before each rising edge
    always begin
        @(negedge clk);
        #(CLK_PERIOD/2 - 1);
        if (rst_n && cmd_valid && cmd_ready) acc_flag = 1'b1;
        if (rst_n && ((|eng_issue) || cfg_issue)) begin
            mon_got = {cfg_issue, eng_issue, iss_src, iss_dst, iss_addr, iss_len};
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R7 unexpected issue actual=%0h expected=none", mon_got);
            end else begin
                mon_exp = exp_q.pop_front();
                check("R2", "issued item", 64'(mon_got), 64'(mon_exp));
            end
        end
    end

    task automatic expect_issue(input logic cfg, input logic [4:0] eng, input logic [2:0] s,
                                input logic [2:0] d, input logic [31:0] a, input logic [15:0] l);
        exp_q.push_back({cfg, eng, s, d, a, l});
    endtask

    task automatic drive(input logic [3:0] op, input logic [2:0] s, input logic [2:0] d,
                         input logic [31:0] a, input logic [15:0] l);
        @(negedge clk);
        cmd_op = op; cmd_src = s; cmd_dst = d; cmd_addr = a; cmd_len = l;
        cmd_valid = 1'b1;
        #1;
    endtask

    task automatic wait_accept(input string req);
        int n = 0;
        while (n < 40) begin
            @(posedge clk);
            n++;
            if (acc_flag) break;
        end
        check(req, "command accepted", 64'(acc_flag), 64'(1));
        acc_flag = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic now_ready(input string req, input logic exp);
        check(req, "cmd_ready", 64'(cmd_ready), 64'(exp));
    endtask

    task automatic step_ready(input string req, input logic exp);
        @(negedge clk);
        #1;
        now_ready(req, exp);
    endtask

    task automatic rel_in(input logic [NP-1:0] m);
        @(negedge clk); in_rel = m;
        @(negedge clk); in_rel = '0;
        #1;
    endtask

    task automatic rel_out(input logic [NP-1:0] m);
        @(negedge clk); out_rel = m;
        @(negedge clk); out_rel = '0;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 4'd9; cmd_src = '0; cmd_dst = '0;
        cmd_addr = '0; cmd_len = '0; eng_free = 5'h1F; in_rel = '0; out_rel = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1: quiet during reset
        check("R1", "eng_issue in reset", 64'(eng_issue), 64'(0));
        check("R1", "cfg_issue in reset", 64'(cfg_issue), 64'(0));
        now_ready("R1", 1'b0);
        @(negedge clk); rst_n = 1'b1; #1;
        now_ready("R1", 1'b1);

        // R2/R3: each stream kind routes to its engine, distinct ports
        expect_issue(0, E_MRD, 3'd0, 3'd1, 32'h100, 16'd4);
        drive(4'd1, 3'd0, 3'd1, 32'h100, 16'd4);  now_ready("R2", 1'b1); wait_accept("R2");
        expect_issue(0, E_MWR, 3'd2, 3'd0, 32'h200, 16'd5);
        drive(4'd2, 3'd2, 3'd0, 32'h200, 16'd5);  wait_accept("R2");
        expect_issue(0, E_SRD, 3'd0, 3'd3, 32'h300, 16'd6);
        drive(4'd3, 3'd0, 3'd3, 32'h300, 16'd6);  wait_accept("R2");
        expect_issue(0, E_SWR, 3'd4, 3'd0, 32'h400, 16'd7);
        drive(4'd4, 3'd4, 3'd0, 32'h400, 16'd7);  wait_accept("R2");
        expect_issue(0, E_REC, 3'd0, 3'd5, 32'h55, 16'd8);
        drive(4'd5, 3'd0, 3'd5, 32'h55, 16'd8);   wait_accept("R2");
        expect_issue(0, E_REC, 3'd6, 3'd6, 32'h0, 16'd9);
        drive(4'd6, 3'd6, 3'd6, 32'h0, 16'd9);    wait_accept("R2");
        // R3: output port 1 is free although input port 1 is held
        expect_issue(0, E_MWR, 3'd1, 3'd0, 32'h600, 16'd2);
        drive(4'd2, 3'd1, 3'd0, 32'h600, 16'd2);  now_ready("R3", 1'b1); wait_accept("R3");

        // R4: input port hazard, released by in_rel
        drive(4'd1, 3'd0, 3'd1, 32'h700, 16'd3);
        now_ready("R4", 1'b0);
        step_ready("R4", 1'b0);
        step_ready("R4", 1'b0);
        expect_issue(0, E_MRD, 3'd0, 3'd1, 32'h700, 16'd3);
        rel_in(8'h02);
        now_ready("R4", 1'b1);
        wait_accept("R4");

        // R5: output port hazard, released by out_rel
        drive(4'd4, 3'd4, 3'd0, 32'h800, 16'd1);
        now_ready("R5", 1'b0);
        step_ready("R5", 1'b0);
        expect_issue(0, E_SWR, 3'd4, 3'd0, 32'h800, 16'd1);
        rel_out(8'h10);
        now_ready("R5", 1'b1);
        wait_accept("R5");

        // R8: scratchpad-read barrier ignores the constant stream on port 5
        drive(4'd7, 3'd0, 3'd0, 32'h0, 16'd0);
        now_ready("R8", 1'b0);
        rel_in(8'h20);
        now_ready("R8", 1'b0);
        rel_in(8'h08);
        now_ready("R8", 1'b1);
        wait_accept("R8");

        // R9: scratchpad-write barrier ignores the memory-write stream on port 2
        drive(4'd8, 3'd0, 3'd0, 32'h0, 16'd0);
        now_ready("R9", 1'b0);
        rel_out(8'h04);
        now_ready("R9", 1'b0);
        rel_out(8'h10);
        now_ready("R9", 1'b1);
        wait_accept("R9");

        // R6: engine busy stalls, free releases in the same cycle
        @(negedge clk); eng_free = 5'b11110;
        drive(4'd1, 3'd0, 3'd7, 32'h900, 16'd2);
        now_ready("R6", 1'b0);
        step_ready("R6", 1'b0);
        expect_issue(0, E_MRD, 3'd0, 3'd7, 32'h900, 16'd2);
        @(negedge clk); eng_free = 5'h1F; #1;
        now_ready("R6", 1'b1);
        wait_accept("R6");

        // R11: configure waits for every port; port-to-port still holds output 6 (R3)
        drive(4'd0, 3'd0, 3'd0, 32'hC0, 16'd12);
        now_ready("R11", 1'b0);
        rel_in(8'hFF);
        now_ready("R11", 1'b0);
        rel_out(8'hBF);
        now_ready("R3", 1'b0);
        expect_issue(1, 5'd0, 3'd0, 3'd0, 32'hC0, 16'd12);
        rel_out(8'h40);
        now_ready("R11", 1'b1);
        wait_accept("R11");

        // R10: full barrier waits for one stream
        expect_issue(0, E_MRD, 3'd0, 3'd0, 32'hA0, 16'd1);
        drive(4'd1, 3'd0, 3'd0, 32'hA0, 16'd1);   wait_accept("R10");
        drive(4'd9, 3'd0, 3'd0, 32'h0, 16'd0);
        now_ready("R10", 1'b0);
        step_ready("R10", 1'b0);
        rel_in(8'h01);
        now_ready("R10", 1'b1);
        wait_accept("R10");

        // R12: unknown opcode drains with no issue
        drive(4'hF, 3'd1, 3'd1, 32'hDEAD, 16'd1);
        now_ready("R12", 1'b1);
        check("R12", "eng_issue", 64'(eng_issue), 64'(0));
        wait_accept("R12");

        repeat (2) @(negedge clk);
        check("R7", "pending expected issues", 64'(exp_q.size()), 64'(0));
        summary();
    end

endmodule